// File: doc/BRIEF.md
# Reset Sequencer with Strap Capture

This block generates the internal reset of a network transceiver. It has two reset sources. One is a power-on indication that acts at once, whatever the state of the external pin. The other is an active-low external reset pin. The pin is first brought into the clock domain by a two-stage synchronizer. It must then stay low for a full minimum window before it counts as a reset request, so shorter glitches are ignored. With either source, the internal reset stays asserted for the full minimum window after the source goes away. A ready flag then tells the rest of the chip that the registers may be accessed.

On the last clock cycle before the internal reset is released, the block samples five pin straps and two configuration pins. The five straps come from the LED/address pads and are copied into a five-bit status field. The configuration pins set an encoder-bypass control bit and a loopback control bit, but only while auto-negotiation is disabled. All captured values stay constant until the next reset, and they are cleared when a new reset begins. The window length is the clock rate in kHz multiplied by the window in microseconds, divided by 1000 and rounded up. With the defaults of 25 000 kHz and 1000 µs this gives 25 000 cycles.

Top module: `rst_strap_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_n_o`, `ready_o`, `strap_stat_o`, `enc_bypass_o` and `loopback_o` are all 0 at once, whatever `ext_rst_n_i` does. After `por_i` falls, `core_rst_n_o` rises on the S-th rising clock edge, where S is the window length in cycles.
- R2: `ext_rst_n_i` passes through two synchronizer flops. If the pin is held low long enough to be seen low by S consecutive clock edges, `core_rst_n_o` falls on edge S+3, counting the first edge that sees the pin low as edge 1. A low pulse seen by fewer than S edges has no effect on any output.
- R3: After a qualified pin reset, count the first edge that sees the pin high again as edge 1. `core_rst_n_o` rises on edge S+3. If the pin is then low again for a full window, reset is re-entered.
- R4: `ready_o` rises one edge after `core_rst_n_o` rises, and it falls on the same edge on which `core_rst_n_o` falls. `ready_o` is never high while `core_rst_n_o` is low.
- R5: On the edge that releases the internal reset, `strap_stat_o` takes the value of `strap_i`. Each index is mapped to status-register bits 7..3 as follows:
  - index 4 is the 10 Mb/s pad (bit 7);
  - index 3 is the activity pad;
  - index 2 is the link pad;
  - index 1 is the duplex pad;
  - index 0 is the 100 Mb/s pad (bit 3).

  The field then holds until the next reset entry, which clears it to 0.
- R6: When `an_en_i` is 0 at capture, `enc_bypass_o` takes the value of `cfg0_i`. A value of 0 keeps the MLT3 encoder/decoder in use, and 1 bypasses it.
- R7: When `an_en_i` is 0 at capture, `loopback_o` (control-register bit 14) takes the value of `cfg1_i`.
- R8: When `an_en_i` is 1 at capture, `enc_bypass_o` and `loopback_o` are 0, whatever the configuration pins are.
- R9: S = ceil(`CLK_KHZ` × `RESET_US` / 1000). For example, `CLK_KHZ`=20 and `RESET_US`=1000 give S=20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset indication, active high, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to the clock |
| strap_i | input | 5 | Strap levels from the LED/address pads |
| cfg0_i | input | 1 | Configuration pin for encoder bypass |
| cfg1_i | input | 1 | Configuration pin for loopback |
| an_en_i | input | 1 | Auto-negotiation enabled |
| core_rst_n_o | output | 1 | Internal reset, active low |
| ready_o | output | 1 | Reset complete; registers may be accessed |
| strap_stat_o | output | 5 | Captured strap field (status bits 7..3) |
| enc_bypass_o | output | 1 | Captured encoder-bypass control bit |
| loopback_o | output | 1 | Captured loopback control bit |

## Verification
Two events can collide on neighbouring edges: the stretch counter finishing, which releases reset and strobes the capture, and a fresh pin reset that qualifies at the same time. The bench provokes this by letting the reset pin go high for exactly one clock and then holding it low again. The requalification window then ends one edge after the release. The expected result is that `core_rst_n_o` is high for a single cycle and `ready_o` never rises. A behavioural reference model built from integers is compared against every output on every clock, and it judges the captured fields through the release and the following clear.

// File: rtl/rss_pkg.sv
package rss_pkg;

    localparam int STRAP_W = 5;

    // Cycles in the minimum reset window, rounded up
    function automatic int stretch_cycles(input int clk_khz, input int reset_us);
        return (clk_khz * reset_us + 999) / 1000;
    endfunction

    typedef struct packed {
        logic [STRAP_W-1:0] straps;
        logic               enc_bypass;
        logic               loopback;
    } cap_t;

endpackage

// File: rtl/rss_sync.sv
module rss_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rss_low_qual.sv
module rss_low_qual #(
    parameter int STRETCH = 25000,
    parameter int CNT_W   = $clog2(STRETCH + 1)
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic low_i,
    output logic qual_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STRETCH);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!low_i)              cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qual_o = (cnt_q == LIMIT);

    AST_QUAL_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (arst_i)
        qual_o |-> $past(low_i)); // R2
    AST_HIGH_DROPS_QUAL: assert property (@(posedge clk_i) disable iff (arst_i)
        !low_i |=> !qual_o); // R3

endmodule

// File: rtl/rss_stretch.sv
module rss_stretch #(
    parameter int STRETCH = 25000,
    parameter int CNT_W   = $clog2(STRETCH + 1)
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic qual_i,
    output logic in_rst_o,
    output logic ready_o,
    output logic strobe_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH - 1);

    typedef struct packed {
        logic             in_rst;
        logic             ready;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        strobe_o = 1'b0;
        if (qual_i) begin
            st_d.in_rst = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.in_rst) begin
            if (st_q.cnt == LAST) begin
                st_d.in_rst = 1'b0;
                strobe_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.ready = !st_q.in_rst && !st_d.in_rst;
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q <= '{in_rst: 1'b1, ready: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign in_rst_o = st_q.in_rst;
    assign ready_o  = st_q.ready;

    AST_QUAL_ENTERS_RESET: assert property (@(posedge clk_i) disable iff (arst_i)
        qual_i |=> in_rst_o); // R2
    AST_STROBE_RELEASES: assert property (@(posedge clk_i) disable iff (arst_i)
        strobe_o |=> !in_rst_o); // R5
    AST_READY_LAGS: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(ready_o) |-> !in_rst_o && $past(!in_rst_o)); // R4

endmodule

// File: rtl/rss_capture.sv
module rss_capture
    import rss_pkg::*;
(
    input  logic               clk_i,
    input  logic               arst_i,
    input  logic               clear_i,
    input  logic               strobe_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               cfg0_i,
    input  logic               cfg1_i,
    input  logic               an_en_i,
    output cap_t               cap_o
);

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (clear_i) begin
            cap_d = '0;
        end else if (strobe_i) begin
            cap_d.straps     = strap_i;
            cap_d.enc_bypass = !an_en_i && cfg0_i;
            cap_d.loopback   = !an_en_i && cfg1_i;
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_o = cap_q;

    AST_STRAPS_TAKEN: assert property (@(posedge clk_i) disable iff (arst_i)
        strobe_i && !clear_i |=> cap_o.straps == $past(strap_i)); // R5
    AST_AN_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (arst_i)
        strobe_i && an_en_i |=> !cap_o.enc_bypass && !cap_o.loopback); // R8
    AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (arst_i)
        clear_i |=> cap_o == '0); // R5

endmodule

// File: rtl/rst_strap_seq.sv
module rst_strap_seq
    import rss_pkg::*;
#(
    parameter int CLK_KHZ  = 25000,
    parameter int RESET_US = 1000
) (
    input  logic               clk_i,
    input  logic               por_i,
    input  logic               ext_rst_n_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               cfg0_i,
    input  logic               cfg1_i,
    input  logic               an_en_i,
    output logic               core_rst_n_o,
    output logic               ready_o,
    output logic [STRAP_W-1:0] strap_stat_o,
    output logic               enc_bypass_o,
    output logic               loopback_o
);

    localparam int STRETCH = stretch_cycles(CLK_KHZ, RESET_US);
    localparam int CNT_W   = $clog2(STRETCH + 1);

    logic ext_sync, qual, in_rst, strobe;
    cap_t cap;

    rss_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk_i (clk_i),
        .arst_i(por_i),
        .d_i   (ext_rst_n_i),
        .q_o   (ext_sync)
    );

    rss_low_qual #(.STRETCH(STRETCH), .CNT_W(CNT_W)) u_qual (
        .clk_i (clk_i),
        .arst_i(por_i),
        .low_i (!ext_sync),
        .qual_o(qual)
    );

    rss_stretch #(.STRETCH(STRETCH), .CNT_W(CNT_W)) u_stretch (
        .clk_i   (clk_i),
        .arst_i  (por_i),
        .qual_i  (qual),
        .in_rst_o(in_rst),
        .ready_o (ready_o),
        .strobe_o(strobe)
    );

    rss_capture u_cap (
        .clk_i   (clk_i),
        .arst_i  (por_i),
        .clear_i (qual),
        .strobe_i(strobe),
        .strap_i (strap_i),
        .cfg0_i  (cfg0_i),
        .cfg1_i  (cfg1_i),
        .an_en_i (an_en_i),
        .cap_o   (cap)
    );

    assign core_rst_n_o = !in_rst;
    assign strap_stat_o = cap.straps;
    assign enc_bypass_o = cap.enc_bypass;
    assign loopback_o   = cap.loopback;

    // Checker: length of the current low phase of the internal reset, saturating
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(STRETCH);
    logic [CNT_W-1:0] rst_len_d, rst_len_q;

    always_comb begin
        if (core_rst_n_o)            rst_len_d = '0;
        else if (rst_len_q == LEN_MAX) rst_len_d = rst_len_q;
        else                         rst_len_d = rst_len_q + 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) rst_len_q <= '0;
        else       rst_len_q <= rst_len_d;
    end

    AST_MIN_STRETCH: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(core_rst_n_o) |-> rst_len_q == LEN_MAX); // R1
    AST_NOT_READY_IN_RESET: assert property (@(posedge clk_i) disable iff (por_i)
        !core_rst_n_o |-> !ready_o); // R4
    AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
        ready_o && $past(ready_o) |-> $stable(strap_stat_o) && $stable(enc_bypass_o)
                                      && $stable(loopback_o)); // R5

endmodule

// File: tb/rst_strap_seq_bench.sv
module rst_strap_seq_bench;

    localparam int CLK_KHZ  = 20;
    localparam int RESET_US = 1000;
    localparam int S        = 20;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_n = 1'b1;
    logic [4:0] straps = 5'b10110;
    logic       cfg0 = 1'b1, cfg1 = 1'b0, an = 1'b0;
    logic       core_rst_n, ready, byp, loopb;
    logic [4:0] stat;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    rst_strap_seq #(.CLK_KHZ(CLK_KHZ), .RESET_US(RESET_US)) u_rst_strap_seq (
        .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .strap_i(straps),
        .cfg0_i(cfg0), .cfg1_i(cfg1), .an_en_i(an),
        .core_rst_n_o(core_rst_n), .ready_o(ready), .strap_stat_o(stat),
        .enc_bypass_o(byp), .loopback_o(loopb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_s1, m_s2, m_inrst, m_ready, m_byp, m_loop, m_q, m_old;
    int       m_low, m_cnt;
    bit [4:0] m_strap;

    always @(posedge clk or posedge por) begin
        if (por) begin
            m_s1 = 1; m_s2 = 1; m_low = 0; m_inrst = 1; m_cnt = 0;
            m_ready = 0; m_strap = 0; m_byp = 0; m_loop = 0;
        end else begin
            m_q   = (m_low == S);
            m_old = m_inrst;
            if (m_s2) m_low = 0;
            else if (m_low < S) m_low = m_low + 1;
            m_s2 = m_s1;
            m_s1 = ext_n;
            if (m_q) begin
                m_inrst = 1; m_cnt = 0; m_strap = 0; m_byp = 0; m_loop = 0;
            end else if (m_inrst) begin
                if (m_cnt == S - 1) begin
                    m_inrst = 0;
                    m_strap = straps;
                    m_byp   = !an && cfg0;
                    m_loop  = !an && cfg1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            m_ready = !m_old && !m_inrst;
        end
    end

    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk(core_rst_n == !m_inrst, "R3 model core_rst_n", int'(core_rst_n), int'(!m_inrst));
            chk(ready == m_ready, "R4 model ready", int'(ready), int'(m_ready));
            chk(stat == m_strap, "R5 model strap field", int'(stat), int'(m_strap));
            chk(byp == m_byp, "R6 model enc_bypass", int'(byp), int'(m_byp));
            chk(loopb == m_loop, "R7 model loopback", int'(loopb), int'(m_loop));
        end
    end

    // ---------------- directed sequence ----------------
    task automatic count_until(input bit want, output int n);
        n = 0;
        do begin
            @(posedge clk); #2; n++;
        end while (core_rst_n != want && n < 1000);
    endtask

    initial begin
        int n;
        bit bad;
        repeat (3) @(posedge clk);
        #2;
        chk(core_rst_n == 0 && ready == 0, "R1 reset state outputs", int'(core_rst_n), 0);
        chk(stat == 0 && byp == 0 && loopb == 0, "R1 reset state fields", int'(stat), 0);

        // power-on release
        @(negedge clk) por = 1'b0;
        count_until(1'b1, n);
        chk(n == S, "R1 R9 power-on stretch edges", n, S);
        chk(ready == 0, "R4 ready lags release", int'(ready), 0);
        @(posedge clk); #2;
        chk(ready == 1, "R4 ready one edge later", int'(ready), 1);
        chk(stat == 5'b10110, "R5 straps captured", int'(stat), 22);
        chk(byp == 1, "R6 bypass from cfg0", int'(byp), 1);
        chk(loopb == 0, "R7 loopback from cfg1", int'(loopb), 0);

        // straps change after capture: field holds
        @(negedge clk) straps = 5'b01001;
        repeat (5) @(posedge clk);
        #2;
        chk(stat == 5'b10110, "R5 field holds after capture", int'(stat), 22);

        // short pulse ignored
        @(negedge clk) ext_n = 1'b0;
        repeat (S - 1) @(negedge clk);
        ext_n = 1'b1;
        bad = 0;
        repeat (S + 10) begin
            @(posedge clk); #2;
            if (!core_rst_n || !ready) bad = 1;
        end
        chk(!bad, "R2 short pulse ignored", int'(bad), 0);

        // qualified pin reset
        @(negedge clk) ext_n = 1'b0;
        count_until(1'b0, n);
        chk(n == S + 3, "R2 qualified reset entry edge", n, S + 3);
        chk(stat == 0 && ready == 0, "R5 fields cleared on entry", int'(stat), 0);
        repeat (10) @(negedge clk);
        cfg0 = 1'b0; cfg1 = 1'b1; straps = 5'b01001; ext_n = 1'b1;
        count_until(1'b1, n);
        chk(n == S + 3, "R3 release edge after pin high", n, S + 3);
        chk(stat == 5'b01001, "R5 new straps captured", int'(stat), 9);
        chk(byp == 0, "R6 bypass cleared by cfg0 low", int'(byp), 0);
        chk(loopb == 1, "R7 loopback set by cfg1 high", int'(loopb), 1);

        // auto-negotiation enabled
        @(negedge clk) an = 1'b1; cfg0 = 1'b1; cfg1 = 1'b1; ext_n = 1'b0;
        count_until(1'b0, n);
        repeat (3) @(negedge clk);
        ext_n = 1'b1;
        count_until(1'b1, n);
        @(posedge clk); #2;
        chk(byp == 0 && loopb == 0, "R8 an enabled forces zero", int'({byp, loopb}), 0);
        chk(stat == 5'b01001, "R5 straps with an enabled", int'(stat), 9);

        // release and requalification on neighbouring edges
        @(negedge clk) an = 1'b0; ext_n = 1'b0;
        count_until(1'b0, n);
        repeat (5) @(negedge clk);
        ext_n = 1'b1;
        @(negedge clk) ext_n = 1'b0;
        count_until(1'b1, n);
        chk(n == S + 2, "R3 release before requalification", n, S + 2);
        chk(ready == 0, "R4 ready low at brief release", int'(ready), 0);
        @(posedge clk); #2;
        chk(core_rst_n == 0, "R3 reset re-entered next edge", int'(core_rst_n), 0);
        chk(ready == 0, "R4 ready never rose", int'(ready), 0);
        repeat (3) @(negedge clk);
        ext_n = 1'b1;
        count_until(1'b1, n);
        chk(n == S + 3, "R3 final release", n, S + 3);

        // power-on during operation
        repeat (4) @(negedge clk);
        por = 1'b1;
        #1;
        chk(core_rst_n == 0 && ready == 0 && stat == 0, "R1 asynchronous power-on",
            int'(core_rst_n), 0);
        @(negedge clk) por = 1'b0;
        count_until(1'b1, n);
        chk(n == S, "R1 stretch after second power-on", n, S);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule